// File: doc/BRIEF.md
# One-Wire ROM Search Triplet Sequencer

This block carries out a single step of the one-wire ROM search on top of a separate bit-slot engine. After a start strobe it requests two read slots. The first returns the ID bit at the current position and the second returns that bit's complement. From these two values it picks a branch direction and then requests a write slot that places the direction on the bus. A higher-level search controller calls it once for each of the 64 ROM bit positions. That controller supplies a preferred direction, which is used when devices on the bus disagree.

Slots are requested through a level request and a one-cycle acknowledge. The request names the slot kind and, for a write, the bit to send. The step's outcome comes back as a packed 3-bit code alongside a one-cycle done strobe. If no device answers (both reads return 1), the step ends early and the write slot is not issued.

Top module: `ow_triplet_seq`

## Requirements
- R1: After reset, `slot_req_o`, `slot_write_o` and `done_o` are 0 and `result_o` is 3'b000.
- R2: When `start_i` is high while the sequencer is idle, `slot_req_o` is 1 with `slot_write_o` = 0 in the next cycle. `pref_dir_i` is sampled in that same start cycle.
- R3: A slot request stays asserted with unchanged kind and write bit until `slot_ack_i` is sampled high. Without an acknowledge the step does not advance.
- R4: Slots run in a fixed order: a read slot for the ID bit, then a read slot for the complement bit, then a write slot (`slot_write_o` = 1). `slot_rbit_i` is latched on each read acknowledge.
- R5: If the ID and complement bits are both 1, the step ends after the second read with code 3'b011 and no write slot is issued.
- R6: If both bits are 0, the direction is the sampled preferred direction. The write bit equals that direction and the code is 3'b100 (direction 1) or 3'b000 (direction 0).
- R7: If exactly one bit is 1, the direction equals the ID bit. The code is 3'b101 for ID bit 1 and 3'b010 for ID bit 0.
- R8: Code layout: bit 0 is the ID bit, bit 1 is the complement bit, bit 2 is the direction taken. The written bit equals code bit 2.
- R9: `done_o` is high for exactly one cycle, in the cycle after the final acknowledge of the step. `result_o` is updated in that cycle and holds its value until the next step completes.
- R10: `start_i` while a step is in progress is ignored: the step neither restarts nor picks up a new preferred direction, and no new step follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin one search step (ignored while busy) |
| pref_dir_i | input | 1 | Direction to take when devices disagree |
| done_o | output | 1 | One-cycle strobe at step completion |
| result_o | output | 3 | Step code {direction, complement, id} |
| slot_req_o | output | 1 | Slot request to the bit-slot engine |
| slot_write_o | output | 1 | 1 = write slot, 0 = read slot |
| slot_wbit_o | output | 1 | Bit to drive during a write slot |
| slot_ack_i | input | 1 | One-cycle slot completion from the engine |
| slot_rbit_i | input | 1 | Bus value sampled by a read slot, valid with the acknowledge |

## Verification
Every result has a fixed latency, because each state change is one register stage. The first read request appears one cycle after the start cycle. Each following request, or the done strobe, appears one cycle after the acknowledge that closed the previous slot. The done strobe therefore comes one cycle after the second read acknowledge on the error path and one cycle after the write acknowledge otherwise. The bench drives its inputs on falling edges and samples on the falling edge that follows each rising edge concerned, so every check lands exactly one register stage after its cause. Acknowledge latencies of zero and several cycles are used to show that the request holds and nothing advances early.

// File: rtl/ow_triplet_pkg.sv
package ow_triplet_pkg;

    localparam int CODE_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RD_ID  = 2'd1,
        ST_RD_CMP = 2'd2,
        ST_WR_DIR = 2'd3
    } step_state_e;

    typedef struct packed {
        logic dir;
        logic cmp;
        logic id;
    } step_code_t;

    localparam step_code_t CODE_NO_DEVICE = '{dir: 1'b0, cmp: 1'b1, id: 1'b1};

endpackage

// File: rtl/ow_triplet_decide.sv
module ow_triplet_decide
    import ow_triplet_pkg::*;
(
    input  logic       id_bit_i,
    input  logic       cmp_bit_i,
    input  logic       pref_dir_i,
    output logic       no_device_o,
    output logic       dir_o,
    output step_code_t code_o
);

    always_comb begin
        no_device_o = id_bit_i & cmp_bit_i;
        if (id_bit_i == cmp_bit_i) begin
            // disagreement (00) follows the caller; 11 is the abort case
            dir_o = no_device_o ? 1'b0 : pref_dir_i;
        end else begin
            dir_o = id_bit_i;
        end
        code_o.id  = id_bit_i;
        code_o.cmp = cmp_bit_i;
        code_o.dir = dir_o;
    end

endmodule

// File: rtl/ow_triplet_ctrl.sv
module ow_triplet_ctrl
    import ow_triplet_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       pref_dir_i,
    input  logic       slot_ack_i,
    input  logic       slot_rbit_i,
    input  logic       dec_no_device_i,
    input  logic       dec_dir_i,
    input  step_code_t dec_code_i,
    output logic       dec_id_o,
    output logic       dec_cmp_o,
    output logic       dec_pref_o,
    output logic       done_o,
    output step_code_t result_o,
    output logic       slot_req_o,
    output logic       slot_write_o,
    output logic       slot_wbit_o
);

    typedef struct packed {
        step_state_e st;
        logic        id;
        logic        pref;
        logic        dir;
        logic        done;
        step_code_t  res;
    } ctrl_t;

    ctrl_t r_q, r_d;

    // decision sees the latched ID bit and the complement bit live on its ack
    assign dec_id_o   = r_q.id;
    assign dec_cmp_o  = slot_rbit_i;
    assign dec_pref_o = r_q.pref;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.pref = pref_dir_i;
                    r_d.st   = ST_RD_ID;
                end
            end
            ST_RD_ID: begin
                if (slot_ack_i) begin
                    r_d.id = slot_rbit_i;
                    r_d.st = ST_RD_CMP;
                end
            end
            ST_RD_CMP: begin
                if (slot_ack_i) begin
                    if (dec_no_device_i) begin
                        r_d.res  = dec_code_i;
                        r_d.done = 1'b1;
                        r_d.st   = ST_IDLE;
                    end else begin
                        r_d.dir = dec_dir_i;
                        r_d.res = dec_code_i;
                        r_d.st  = ST_WR_DIR;
                    end
                end
            end
            ST_WR_DIR: begin
                if (slot_ack_i) begin
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    // the code is staged in r_q.res before the write, so result_o is muxed
    // to the previous value until the step finishes
    step_code_t shown_q, shown_d;

    always_comb begin
        shown_d = shown_q;
        if (r_d.done) shown_d = r_d.res;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q     <= '{st: ST_IDLE, id: 1'b0, pref: 1'b0, dir: 1'b0,
                         done: 1'b0, res: '0};
            shown_q <= '0;
        end else begin
            r_q     <= r_d;
            shown_q <= shown_d;
        end
    end

    assign done_o       = r_q.done;
    assign result_o     = shown_q;
    assign slot_req_o   = (r_q.st != ST_IDLE);
    assign slot_write_o = (r_q.st == ST_WR_DIR);
    assign slot_wbit_o  = (r_q.st == ST_WR_DIR) ? r_q.dir : 1'b0;

endmodule

// File: rtl/ow_triplet_seq.sv
module ow_triplet_seq
    import ow_triplet_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              pref_dir_i,
    output logic              done_o,
    output logic [CODE_W-1:0] result_o,
    output logic              slot_req_o,
    output logic              slot_write_o,
    output logic              slot_wbit_o,
    input  logic              slot_ack_i,
    input  logic              slot_rbit_i
);

    logic       dec_id, dec_cmp, dec_pref, dec_no_dev, dec_dir;
    step_code_t dec_code, res;

    ow_triplet_decide u_decide (
        .id_bit_i    (dec_id),
        .cmp_bit_i   (dec_cmp),
        .pref_dir_i  (dec_pref),
        .no_device_o (dec_no_dev),
        .dir_o       (dec_dir),
        .code_o      (dec_code)
    );

    ow_triplet_ctrl u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_i         (start_i),
        .pref_dir_i      (pref_dir_i),
        .slot_ack_i      (slot_ack_i),
        .slot_rbit_i     (slot_rbit_i),
        .dec_no_device_i (dec_no_dev),
        .dec_dir_i       (dec_dir),
        .dec_code_i      (dec_code),
        .dec_id_o        (dec_id),
        .dec_cmp_o       (dec_cmp),
        .dec_pref_o      (dec_pref),
        .done_o          (done_o),
        .result_o        (res),
        .slot_req_o      (slot_req_o),
        .slot_write_o    (slot_write_o),
        .slot_wbit_o     (slot_wbit_o)
    );

    assign result_o = res;

endmodule

// File: rtl/ow_triplet_seq_chk.sv
module ow_triplet_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       done_o,
    input logic [2:0] result_o,
    input logic       slot_req_o,
    input logic       slot_write_o,
    input logic       slot_wbit_o,
    input logic       slot_ack_i
);

    p_idle_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot_req_o && start_i) |=> (slot_req_o && !slot_write_o));

    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_req_o && !slot_ack_i) |=>
            (slot_req_o && $stable(slot_write_o) && $stable(slot_wbit_o)));

    p_write_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slot_write_o) |-> $past(slot_req_o && !slot_write_o && slot_ack_i));

    p_no_req_at_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !slot_req_o);

    p_wbit_matches_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && result_o != 3'b011) |->
            ($past(slot_write_o) && $past(slot_wbit_o) == result_o[2]));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_result_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |=> (done_o || $stable(result_o)));

endmodule

bind ow_triplet_seq ow_triplet_seq_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .done_o       (done_o),
    .result_o     (result_o),
    .slot_req_o   (slot_req_o),
    .slot_write_o (slot_write_o),
    .slot_wbit_o  (slot_wbit_o),
    .slot_ack_i   (slot_ack_i)
);

// File: tb/ow_triplet_seq_tb_top.sv
module ow_triplet_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       pref_dir_i = 1'b0;
    logic       done_o;
    logic [2:0] result_o;
    logic       slot_req_o, slot_write_o, slot_wbit_o;
    logic       slot_ack_i = 1'b0;
    logic       slot_rbit_i = 1'b0;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    ow_triplet_seq dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .pref_dir_i   (pref_dir_i),
        .done_o       (done_o),
        .result_o     (result_o),
        .slot_req_o   (slot_req_o),
        .slot_write_o (slot_write_o),
        .slot_wbit_o  (slot_wbit_o),
        .slot_ack_i   (slot_ack_i),
        .slot_rbit_i  (slot_rbit_i)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // service one slot: hold off the acknowledge for lat cycles, then ack with rbit
    task automatic serve_slot(input bit rbit, input int lat, input bit poke);
        for (int i = 0; i < lat; i++) begin
            chk(slot_req_o === 1'b1, "R3 request held", slot_req_o, 1);
            chk(done_o === 1'b0, "R3 no advance without ack", done_o, 0);
            if (poke && i == 0) begin
                start_i    = 1'b1;
                pref_dir_i = ~pref_dir_i;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i     = 1'b0;
        slot_ack_i  = 1'b1;
        slot_rbit_i = rbit;
        @(negedge clk);
        slot_ack_i  = 1'b0;
        slot_rbit_i = 1'b0;
    endtask

    // one full search step; expected values derived from R5..R8
    task automatic run_step(input bit id, input bit cmp, input bit pref,
                            input int lat, input bit poke);
        bit       err;
        bit       dir;
        bit [2:0] code;
        err  = id & cmp;
        dir  = err ? 1'b0 : ((id == cmp) ? pref : id);
        code = {dir, cmp, id};
        @(negedge clk);
        start_i    = 1'b1;
        pref_dir_i = pref;
        @(negedge clk);
        start_i = 1'b0;
        chk(slot_req_o === 1'b1 && slot_write_o === 1'b0, "R2 first read request",
            {slot_req_o, slot_write_o}, 2);
        serve_slot(id, lat, poke);
        chk(slot_req_o === 1'b1 && slot_write_o === 1'b0, "R4 complement read",
            {slot_req_o, slot_write_o}, 2);
        serve_slot(cmp, lat, 1'b0);
        if (err) begin
            chk(done_o === 1'b1, "R5 done after second read", done_o, 1);
            chk(result_o === 3'b011, "R5 no-device code", result_o, 3);
            chk(slot_req_o === 1'b0, "R5 write slot skipped", slot_req_o, 0);
        end else begin
            chk(slot_req_o === 1'b1 && slot_write_o === 1'b1, "R4 write slot",
                {slot_req_o, slot_write_o}, 3);
            chk(slot_wbit_o === dir, (id == cmp) ? "R6 write bit" : "R7 write bit",
                slot_wbit_o, dir);
            serve_slot(1'b0, lat, 1'b0);
            chk(done_o === 1'b1, "R9 done after write ack", done_o, 1);
            chk(result_o === code, (id == cmp) ? "R6 R8 code" : "R7 R8 code",
                result_o, code);
            chk(slot_req_o === 1'b0, "R10 idle after step", slot_req_o, 0);
        end
        @(negedge clk);
        chk(done_o === 1'b0, "R9 done single cycle", done_o, 0);
        chk(result_o === code, "R9 result held", result_o, code);
        chk(slot_req_o === 1'b0, "R10 no restart", slot_req_o, 0);
        repeat (2) @(negedge clk);
        chk(result_o === code, "R9 result held idle", result_o, code);
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk(slot_req_o === 1'b0 && slot_write_o === 1'b0 && done_o === 1'b0,
            "R1 idle outputs", {slot_req_o, slot_write_o, done_o}, 0);
        chk(result_o === 3'b000, "R1 result reset", result_o, 0);
    endtask

    task automatic test_no_device();
        run_step(1'b1, 1'b1, 1'b1, 0, 1'b0);  // R5
    endtask

    task automatic test_conflict();
        run_step(1'b0, 1'b0, 1'b1, 1, 1'b0);  // R6 pref 1 -> 100
        run_step(1'b0, 1'b0, 1'b0, 3, 1'b0);  // R6 pref 0 -> 000
    endtask

    task automatic test_single();
        run_step(1'b1, 1'b0, 1'b0, 2, 1'b0);  // R7 -> 101
        run_step(1'b0, 1'b1, 1'b1, 0, 1'b0);  // R7 -> 010
    endtask

    task automatic test_busy_start();
        // R10: start with flipped preference during the first slot is ignored
        run_step(1'b0, 1'b0, 1'b1, 3, 1'b1);
        run_step(1'b0, 1'b0, 1'b0, 4, 1'b1);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_no_device();
        test_conflict();
        test_single();
        test_busy_start();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule